// File: doc/BRIEF.md
# PDM CIC decimator front end

This block turns one or two 1-bit pulse-density-modulated microphone streams into 22-bit multi-bit samples for a following FIR decimation stage. Two microphones share a single data line: one drives it while the PDM clock is high and is captured on the rising edge, and the other is captured on the falling edge. The PDM clock comes from outside the block. The block watches it from the system clock domain and samples the data line on the system clock edge where each transition is first seen.

Each of the two paths can invert its stream's polarity. Each path then runs a five-stage integrator-comb (CIC) decimator with 26-bit wrap-around arithmetic and a programmable decimation factor. A signed shift scales the result, and the result saturates to 22 bits. The paths have separate start controls. A soft reset, a mute and a stereo/mono selection are shared by both paths. In mono mode both paths take the rising-edge microphone.

Top module: `pdm_cic_frontend`

## Requirements
- R1: While `rst_ni` is low, or `soft_rst_i` is high, both valid outputs are 0 and all integrator, comb, phase and capture state is cleared. After release, outputs match a filter that starts from all-zero state.
- R2: With `stereo_i`=1, path A takes the data line at each rising PDM clock edge and path B takes it at each falling edge. The two paths never capture in the same cycle.
- R3: With `stereo_i`=0, both paths take the rising-edge bit, so they produce identical sample streams when their polarity settings match.
- R4: Data bit 1 enters the filter as +1 and bit 0 as -1. When a path's invert input is 1, that path's input is negated.
- R5: Each path is a cascade of five 26-bit integrators and five 26-bit combs that wrap modulo 2^26. It gives exactly one output per R input samples. R is `decim_i` clamped to the range 5..31: values below 5 act as 5 and values above 31 act as 31.
- R6: A constant all-ones stream at shift 0 settles to +R^5, and an all-zeros stream settles to -R^5.
- R7: `shift_i` is signed. A positive value shifts left, a negative value shifts right arithmetically (toward minus infinity), and values above +4 act as +4. The result saturates to the range -2097152..2097151.
- R8: With `mute_i`=1 every output sample is 0, and valid pulses keep their normal decimated rate.
- R9: A path whose start input is 0 stays cleared and gives no valid pulse. The other path is unaffected.
- R10: A valid pulse appears on the third system clock edge, counting the edge on which the PDM clock transition that completes an R-sample group is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdm_clk_i | input | 1 | PDM clock, synchronous to clk_i and slower than it |
| pdm_data_i | input | 1 | Shared PDM data line |
| soft_rst_i | input | 1 | Soft reset of both paths |
| start_a_i | input | 1 | Run path A |
| start_b_i | input | 1 | Run path B |
| inv_a_i | input | 1 | Invert polarity of path A |
| inv_b_i | input | 1 | Invert polarity of path B |
| mute_i | input | 1 | Force output samples to zero |
| stereo_i | input | 1 | 1: B from falling edge; 0: both from rising edge |
| decim_i | input | 8 | Decimation factor, clamped to 5..31 |
| shift_i | input | 4 | Signed output shift, -8..+4 |
| sample_a_o | output | 22 | Path A output sample |
| valid_a_o | output | 1 | Path A sample strobe |
| sample_b_o | output | 22 | Path B output sample |
| valid_b_o | output | 1 | Path B sample strobe |

## Verification
Some behaviours hold on every cycle and are checked by properties:
- the fixed capture-to-strobe latency;
- the gap of at least one cycle between strobes;
- zero data under mute;
- no strobe from a stopped path;
- the pairing of the two paths' captures in mono mode;
- the exclusion of the two paths' captures in stereo mode.

The filter arithmetic itself can only be shown by scenarios that run long streams against a reference model in the bench. These scenarios cover DC settling to ±R^5, pseudo-random patterns, clamping of the decimation factor, arithmetic right shift of negative values, and saturation. The same applies to soft reset in the middle of a run, which is shown by the filter restarting from zero state.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;
  localparam int NUM_PATHS = 2;

  typedef struct packed {
    logic ev;
    logic bit_v;
  } pdm_smp_t;
endpackage

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture
  import pdm_cic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     stereo_i,
  input  logic     pdm_clk_i,
  input  logic     pdm_data_i,
  output pdm_smp_t smp_a_o,
  output pdm_smp_t smp_b_o
);
  logic     clk_prev_q;
  logic     rise, fall;
  pdm_smp_t smp_a_q, smp_b_q;

  assign rise = pdm_clk_i & ~clk_prev_q;
  assign fall = ~pdm_clk_i & clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q <= 1'b0;
      smp_a_q    <= '0;
      smp_b_q    <= '0;
    end else begin
      clk_prev_q <= pdm_clk_i;
      if (clr_i) begin
        smp_a_q <= '0;
        smp_b_q <= '0;
      end else begin
        smp_a_q.ev    <= rise;
        smp_a_q.bit_v <= pdm_data_i;
        smp_b_q.ev    <= stereo_i ? fall : rise;
        smp_b_q.bit_v <= pdm_data_i;
      end
    end
  end

  assign smp_a_o = smp_a_q;
  assign smp_b_o = smp_b_q;

  p_edge_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stereo_i) |-> !(smp_a_q.ev && smp_b_q.ev));

  p_mono_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!stereo_i) |-> (smp_b_q == smp_a_q));
endmodule

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
  parameter int STAGES = 5,
  parameter int ACC_W  = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] tap [STAGES+1];

  assign tap[0] = x_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    logic signed [ACC_W-1:0] acc_q;
    // each stage adds the previous stage's registered value (pipelined form)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (clr_i)  acc_q <= '0;
      else if (en_i)   acc_q <= acc_q + tap[k];
    end
    assign tap[k+1] = acc_q;
  end

  assign acc_o = tap[STAGES];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int STAGES = 5,
  parameter int ACC_W  = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] stg [STAGES+1];

  assign stg[0] = x_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    logic signed [ACC_W-1:0] dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (clr_i)  dly_q <= '0;
      else if (en_i)   dly_q <= stg[k];
    end
    assign stg[k+1] = stg[k] - dly_q;
  end

  assign y_o = stg[STAGES];
endmodule

// File: rtl/cic_path.sv
module cic_path
  import pdm_cic_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 22,
  parameter int DEC_W   = 8,
  parameter int SHIFT_W = 4,
  parameter int DEC_MIN = 5,
  parameter int DEC_MAX = 31,
  parameter int SH_UP   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  pdm_smp_t                  smp_i,
  input  logic                      inv_i,
  input  logic                      mute_i,
  input  logic [DEC_W-1:0]          decim_i,
  input  logic signed [SHIFT_W-1:0] shift_i,
  output logic signed [OUT_W-1:0]   sample_o,
  output logic                      valid_o
);
  localparam int PH_W = $clog2(DEC_MAX + 1);
  localparam int WIDE = ACC_W + SH_UP + 1;
  localparam logic signed [WIDE-1:0] OMAX = WIDE'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [WIDE-1:0] OMIN = ~OMAX;

  logic [PH_W-1:0]         dec_eff, phase_q;
  logic                    last_ph, dec_pend_q;
  logic signed [ACC_W-1:0] x_in, int_out, comb_out;
  logic signed [WIDE-1:0]  y_ext, scaled;
  logic signed [OUT_W-1:0] sat_v;
  logic signed [OUT_W-1:0] sample_q;
  logic                    valid_q;
  int                      sh_v;

  always_comb begin
    if (decim_i < DEC_W'(DEC_MIN))      dec_eff = PH_W'(DEC_MIN);
    else if (decim_i > DEC_W'(DEC_MAX)) dec_eff = PH_W'(DEC_MAX);
    else                                dec_eff = decim_i[PH_W-1:0];
  end

  assign last_ph = (phase_q == dec_eff - 1'b1);
  assign x_in    = (smp_i.bit_v ^ inv_i) ? ACC_W'(1) : -ACC_W'(1);

  cic_integrator_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (smp_i.ev),
    .x_i    (x_in),
    .acc_o  (int_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= '0;
      dec_pend_q <= 1'b0;
    end else if (clr_i) begin
      phase_q    <= '0;
      dec_pend_q <= 1'b0;
    end else begin
      dec_pend_q <= smp_i.ev && last_ph;
      if (smp_i.ev) phase_q <= last_ph ? '0 : phase_q + 1'b1;
    end
  end

  cic_comb_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (dec_pend_q),
    .x_i    (int_out),
    .y_o    (comb_out)
  );

  always_comb begin
    sh_v = int'(shift_i);
    if (sh_v > SH_UP) sh_v = SH_UP;
    y_ext = {{(WIDE - ACC_W){comb_out[ACC_W-1]}}, comb_out};
    if (sh_v >= 0) scaled = y_ext <<< sh_v;
    else           scaled = y_ext >>> (-sh_v);
    if (scaled > OMAX)      sat_v = OMAX[OUT_W-1:0];
    else if (scaled < OMIN) sat_v = OMIN[OUT_W-1:0];
    else                    sat_v = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else if (clr_i) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= dec_pend_q;
      if (dec_pend_q) sample_q <= mute_i ? '0 : sat_v;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  p_valid_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(smp_i.ev, 2));

  p_valid_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  p_mute_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(mute_i)) |-> (sample_q == '0));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !valid_q);
endmodule

// File: rtl/pdm_cic_frontend.sv
module pdm_cic_frontend
  import pdm_cic_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 22,
  parameter int DEC_W   = 8,
  parameter int SHIFT_W = 4,
  parameter int DEC_MIN = 5,
  parameter int DEC_MAX = 31,
  parameter int SH_UP   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pdm_clk_i,
  input  logic                      pdm_data_i,
  input  logic                      soft_rst_i,
  input  logic                      start_a_i,
  input  logic                      start_b_i,
  input  logic                      inv_a_i,
  input  logic                      inv_b_i,
  input  logic                      mute_i,
  input  logic                      stereo_i,
  input  logic [DEC_W-1:0]          decim_i,
  input  logic signed [SHIFT_W-1:0] shift_i,
  output logic signed [OUT_W-1:0]   sample_a_o,
  output logic                      valid_a_o,
  output logic signed [OUT_W-1:0]   sample_b_o,
  output logic                      valid_b_o
);
  pdm_smp_t                smp_v    [NUM_PATHS];
  logic                    start_v  [NUM_PATHS];
  logic                    inv_v    [NUM_PATHS];
  logic signed [OUT_W-1:0] sample_v [NUM_PATHS];
  logic                    valid_v  [NUM_PATHS];

  assign start_v[0] = start_a_i;
  assign start_v[1] = start_b_i;
  assign inv_v[0]   = inv_a_i;
  assign inv_v[1]   = inv_b_i;

  pdm_edge_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst_i),
    .stereo_i   (stereo_i),
    .pdm_clk_i  (pdm_clk_i),
    .pdm_data_i (pdm_data_i),
    .smp_a_o    (smp_v[0]),
    .smp_b_o    (smp_v[1])
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    cic_path #(
      .STAGES (STAGES),  .ACC_W (ACC_W),  .OUT_W (OUT_W),
      .DEC_W  (DEC_W),   .SHIFT_W (SHIFT_W),
      .DEC_MIN(DEC_MIN), .DEC_MAX (DEC_MAX), .SH_UP (SH_UP)
    ) u_path (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (soft_rst_i | ~start_v[p]),
      .smp_i    (smp_v[p]),
      .inv_i    (inv_v[p]),
      .mute_i   (mute_i),
      .decim_i  (decim_i),
      .shift_i  (shift_i),
      .sample_o (sample_v[p]),
      .valid_o  (valid_v[p])
    );
  end

  assign sample_a_o = sample_v[0];
  assign valid_a_o  = valid_v[0];
  assign sample_b_o = sample_v[1];
  assign valid_b_o  = valid_v[1];
endmodule

// File: tb/pdm_cic_frontend_bench.sv
module pdm_cic_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              pdm_clk = 1'b0, pdm_data = 1'b0;
  logic              soft_rst = 1'b0, start_a = 1'b0, start_b = 1'b0;
  logic              inv_a = 1'b0, inv_b = 1'b0, mute = 1'b0, stereo = 1'b1;
  logic [7:0]        decim = 8'd5;
  logic signed [3:0] shift = 4'sd0;
  logic signed [21:0] sample_a, sample_b;
  logic              valid_a, valid_b;

  pdm_cic_frontend u_pdm_cic_frontend (
    .clk_i(clk), .rst_ni(rst_n), .pdm_clk_i(pdm_clk), .pdm_data_i(pdm_data),
    .soft_rst_i(soft_rst), .start_a_i(start_a), .start_b_i(start_b),
    .inv_a_i(inv_a), .inv_b_i(inv_b), .mute_i(mute), .stereo_i(stereo),
    .decim_i(decim), .shift_i(shift),
    .sample_a_o(sample_a), .valid_a_o(valid_a),
    .sample_b_o(sample_b), .valid_b_o(valid_b)
  );

  int total = 0, bad = 0;
  string tag_s = "R1";
  int cyc = 0, rise_cyc = 0, vcyc_a = 0;
  int cnt_a = 0, cnt_b = 0, last_a = 0, last_b = 0;
  int q_a[$], q_b[$];
  logic [15:0] lfsr = 16'hACE1;

  logic signed [25:0] mi [2][5];
  logic signed [25:0] md [2][5];
  int mph [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear(int p);
    for (int k = 0; k < 5; k++) begin
      mi[p][k] = '0;
      md[p][k] = '0;
    end
    mph[p] = 0;
  endtask

  function automatic int eff_dec();
    if (decim < 8'd5)  return 5;
    if (decim > 8'd31) return 31;
    return int'(decim);
  endfunction

  function automatic int scale(logic signed [25:0] y);
    int v, sh, y32;
    y32 = int'(y);
    sh  = int'(shift);
    if (sh > 4) sh = 4;
    if (sh >= 0) v = y32 <<< sh;
    else         v = y32 >>> (-sh);
    if (v > 2097151)  v = 2097151;
    if (v < -2097152) v = -2097152;
    return v;
  endfunction

  task automatic model_step(int p, bit b);
    logic signed [25:0] x, s, y;
    logic run, inv;
    run = (p == 0) ? start_a : start_b;
    inv = (p == 0) ? inv_a : inv_b;
    if (soft_rst || !run) begin
      model_clear(p);
      return;
    end
    x = (b ^ inv) ? 26'sd1 : -26'sd1;
    for (int k = 4; k > 0; k--) mi[p][k] = mi[p][k] + mi[p][k-1];
    mi[p][0] = mi[p][0] + x;
    if (mph[p] == eff_dec() - 1) begin
      mph[p] = 0;
      s = mi[p][4];
      for (int k = 0; k < 5; k++) begin
        y = s - md[p][k];
        md[p][k] = s;
        s = y;
      end
      if (p == 0) q_a.push_back(mute ? 0 : scale(s));
      else        q_b.push_back(mute ? 0 : scale(s));
    end else begin
      mph[p]++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_a) begin
        cnt_a++;
        last_a = int'(sample_a);
        vcyc_a = cyc;
        if (q_a.size() == 0) chk(tag_s, "A unexpected valid", 1, 0);
        else chk(tag_s, "A sample", int'(sample_a), q_a.pop_front());
      end
      if (valid_b) begin
        cnt_b++;
        last_b = int'(sample_b);
        if (q_b.size() == 0) chk(tag_s, "B unexpected valid", 1, 0);
        else chk(tag_s, "B sample", int'(sample_b), q_b.pop_front());
      end
    end
  end

  task automatic pdm_pair(bit a, bit b);
    @(negedge clk);
    pdm_clk = 1'b1;
    pdm_data = a;
    rise_cyc = cyc;
    model_step(0, a);
    model_step(1, stereo ? b : a);
    repeat (3) @(negedge clk);
    @(negedge clk);
    pdm_clk = 1'b0;
    pdm_data = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic next_rand(output bit o);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    o = lfsr[0];
  endtask

  task automatic do_srst();
    repeat (12) @(negedge clk);
    chk(tag_s, "A queue drained", q_a.size(), 0);
    chk(tag_s, "B queue drained", q_b.size(), 0);
    soft_rst = 1'b1;
    model_clear(0);
    model_clear(1);
    repeat (2) @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    tag_s = "R1";
    @(negedge clk);
    chk("R1", "reset valid_a", int'(valid_a), 0);
    chk("R1", "reset valid_b", int'(valid_b), 0);
    chk("R1", "reset sample_a", int'(sample_a), 0);
    chk("R1", "reset sample_b", int'(sample_b), 0);
  endtask

  task automatic t_latency();
    tag_s = "R10";
    do_srst();
    decim = 8'd5; stereo = 1'b1; start_a = 1'b1; start_b = 1'b0;
    for (int i = 0; i < 5; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R10", "strobe latency", vcyc_a - rise_cyc, 3);
    chk("R9", "stopped path B strobes", cnt_b, 0);
  endtask

  task automatic t_dc_stereo();
    tag_s = "R6";
    do_srst();
    start_a = 1'b1; start_b = 1'b1; decim = 8'd5; shift = 4'sd0;
    for (int i = 0; i < 60; i++) pdm_pair(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R6", "A dc ones", last_a, 3125);
    chk("R2", "B from falling edge dc zeros", last_b, -3125);
  endtask

  task automatic t_pattern();
    int ca, cb;
    bit a, b;
    tag_s = "R5";
    do_srst();
    decim = 8'd16; shift = -4'sd2; inv_b = 1'b1;
    ca = cnt_a; cb = cnt_b;
    for (int i = 0; i < 400; i++) begin
      next_rand(a);
      next_rand(b);
      pdm_pair(a, b);
    end
    repeat (6) @(negedge clk);
    chk("R5", "A output count", cnt_a - ca, 25);
    chk("R5", "B output count", cnt_b - cb, 25);
    inv_b = 1'b0;
  endtask

  task automatic t_mono();
    bit a, b;
    tag_s = "R3";
    do_srst();
    stereo = 1'b0; decim = 8'd8; shift = 4'sd0;
    for (int i = 0; i < 200; i++) begin
      next_rand(a);
      next_rand(b);
      pdm_pair(a, b);
    end
    repeat (6) @(negedge clk);
    chk("R3", "mono B equals A", last_b, last_a);
    stereo = 1'b1;
  endtask

  task automatic t_invert();
    tag_s = "R4";
    do_srst();
    decim = 8'd12; inv_a = 1'b1; inv_b = 1'b0;
    for (int i = 0; i < 100; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R4", "inverted A", last_a, -248832);
    chk("R4", "plain B", last_b, 248832);
    inv_a = 1'b0;
  endtask

  task automatic t_shift();
    tag_s = "R7";
    do_srst();
    decim = 8'd31; shift = 4'sd4;
    for (int i = 0; i < 200; i++) pdm_pair(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R7", "positive saturation", last_a, 2097151);
    chk("R7", "negative saturation", last_b, -2097152);
    do_srst();
    shift = -4'sd8;
    for (int i = 0; i < 200; i++) pdm_pair(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R7", "right shift positive", last_a, 111832);
    chk("R7", "right shift negative floors", last_b, -111833);
    do_srst();
    decim = 8'd5; shift = 4'sd7;
    for (int i = 0; i < 60; i++) pdm_pair(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R7", "shift above +4 acts as +4", last_a, 50000);
    shift = 4'sd0;
  endtask

  task automatic t_mute();
    int ca;
    tag_s = "R8";
    do_srst();
    decim = 8'd5; mute = 1'b1;
    ca = cnt_a;
    for (int i = 0; i < 50; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R8", "muted strobe count", cnt_a - ca, 10);
    chk("R8", "muted sample", last_a, 0);
    do_srst();
    mute = 1'b0;
  endtask

  task automatic t_clamp();
    tag_s = "R5";
    do_srst();
    decim = 8'd3; shift = 4'sd0;
    for (int i = 0; i < 60; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R5", "decim 3 clamps to 5", last_a, 3125);
    do_srst();
    decim = 8'd200; shift = -4'sd8;
    for (int i = 0; i < 200; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R5", "decim 200 clamps to 31", last_a, 111832);
    shift = 4'sd0;
  endtask

  task automatic t_soft_reset_and_start();
    int ca, cb;
    tag_s = "R1";
    do_srst();
    decim = 8'd5; start_a = 1'b1; start_b = 1'b1;
    for (int i = 0; i < 7; i++) pdm_pair(1'b1, 1'b0);
    repeat (12) @(negedge clk);
    soft_rst = 1'b1;
    ca = cnt_a; cb = cnt_b;
    for (int i = 0; i < 10; i++) pdm_pair(1'b1, 1'b0);
    chk("R1", "A strobes under soft reset", cnt_a - ca, 0);
    chk("R1", "B strobes under soft reset", cnt_b - cb, 0);
    soft_rst = 1'b0;
    for (int i = 0; i < 40; i++) pdm_pair(1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk("R1", "A restarts from zero state", last_a, -3125);
    tag_s = "R9";
    start_b = 1'b0;
    ca = cnt_a; cb = cnt_b;
    for (int i = 0; i < 30; i++) pdm_pair(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R9", "stopped B strobes", cnt_b - cb, 0);
    chk("R9", "running A strobes", cnt_a - ca, 6);
    start_b = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear(0);
    model_clear(1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_latency();
    t_dc_stereo();
    t_pattern();
    t_mono();
    t_invert();
    t_shift();
    t_mute();
    t_clamp();
    t_soft_reset_and_start();
    repeat (12) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule